// File: doc/BRIEF.md
# Register Vulnerability Interval Monitor

This block watches the access stream of a register file and keeps, for every register, a running total of the time during which that register held data that was later consumed. Each cycle it can see two read ports and one write port, each with a valid flag and a register index. It also sees a run-start pulse and a run-stop pulse that mark the program's beginning and its exit. A span of time counts only if a read closes it. The span may have opened with a write or with an earlier read. Spans closed by a write are discarded. So are the gap from run start to a register's first access and the tail from its last access to run stop.

Every closed span adds its length in cycles, multiplied by the register width in bytes, to that register's accumulator. The result is in byte-cycle units, and the accumulator saturates at its maximum. Timestamps come from a free-running cycle counter. Software or a test harness reads the totals through a registered query port, and a combinational grand-total output sums all registers.

Top module: `regvuln_monitor`

## Requirements
- R1: After reset, `qry_data` and `total` are both zero.
- R2: A read of register r adds (t_read - t_prev) * REG_BYTES to r's accumulator when r was last accessed at cycle t_prev by a write. Cycle numbers count clock edges.
- R3: A read that follows an earlier read of the same register also adds its span. Several reads after one write therefore total (last read - write) * REG_BYTES, and without a start pulse `total` never decreases.
- R4: A write never changes any accumulator, so a span that a write closes adds nothing.
- R5: The first access to a register after run start adds nothing, even when that access is a read.
- R6: Accesses are tracked only while a run is active. A run begins on the cycle after `run_start` and ends at `run_stop`. Accesses in the start or stop cycle, before any start, or after a stop are ignored. `run_start` clears every accumulator, so `total` is 0 on the next cycle.
- R7: When a read and a write hit the same register in the same cycle, the read is handled first and closes its span. The write then restarts the register's span at that same cycle.
- R8: Two read ports naming the same register in one cycle count as one access and add the span only once.
- R9: An accumulator saturates at 2^ACC_W - 1 and stays there on further reads.
- R10: `qry_data` equals the accumulator of register `qry_idx` as it stood one clock edge earlier, before that edge's update. `total` is the sum of all accumulators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Program start pulse; clears totals and begins tracking |
| run_stop | input | 1 | Program exit pulse; ends tracking |
| rd0_vld | input | 1 | Read port 0 valid |
| rd0_idx | input | IDX_W | Read port 0 register index |
| rd1_vld | input | 1 | Read port 1 valid |
| rd1_idx | input | IDX_W | Read port 1 register index |
| wr_vld | input | 1 | Write port valid |
| wr_idx | input | IDX_W | Write port register index |
| qry_idx | input | IDX_W | Register whose accumulator is queried |
| qry_data | output | ACC_W | Queried accumulator, one cycle after `qry_idx` |
| total | output | TOT_W | Sum of all accumulators |

## Verification
An access presented before a clock edge updates the accumulators at that edge. `total` reflects the update combinationally after the edge. `qry_data` returns the value the selected accumulator held before that same edge. The bench drives inputs at the falling edge and keeps a model that applies each cycle's accesses in cycle order. It samples both outputs at the next falling edge: `total` against the model after the update, and `qry_data` against the model value captured before it. Directed spans use known gaps, such as a write followed by a read six edges later giving 24. Each of these directed checks then queries the register on the following cycle.

// File: rtl/regvuln_pkg.sv
// Shared types and helpers for the register vulnerability monitor.
package regvuln_pkg;

    // What a tracked register does on a given cycle
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,   // no access
        ACT_TOUCH = 2'd1,   // access restarts the span, nothing added
        ACT_CLOSE = 2'd2    // read closes a span and adds it
    } slot_act_e;

    // Saturating add of two 64-bit values against a ceiling
    function automatic logic [63:0] sat_add(input logic [63:0] a,
                                            input logic [63:0] b,
                                            input logic [63:0] ceil);
        logic [64:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s > {1'b0, ceil}) return ceil;
        return s[63:0];
    endfunction

endpackage

// File: rtl/regvuln_cyc.sv
// Free-running cycle counter that supplies timestamps.
// Assumes wrap-around is harmless because spans are taken modulo 2^TS_W.
module regvuln_cyc #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    // Count every clock edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/regvuln_slot.sv
// Per-register span tracker.
// It keeps the last access time and whether the register has been touched
// since run start. A read that closes an armed span adds the span length,
// scaled by the register width in bytes, to a saturating accumulator.
// It assumes the caller has already merged duplicate reads into rd_hit.
module regvuln_slot
    import regvuln_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int ACC_W     = 48,
    parameter int REG_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             disarm,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic [TS_W-1:0]  now,
    output logic [ACC_W-1:0] acc
);
    localparam logic [63:0] ACC_MAX = (64'd1 << ACC_W) - 64'd1;
    localparam logic [63:0] SCALE   = 64'(REG_BYTES);

    logic [TS_W-1:0] last;
    logic            armed;
    slot_act_e       act;
    logic [TS_W-1:0] span;
    logic [63:0]     incr;
    logic [ACC_W-1:0] acc_nxt;

    // Choose the action: the read is served before a same-cycle write
    always_comb begin
        if (rd_hit && armed)       act = ACT_CLOSE;
        else if (rd_hit || wr_hit) act = ACT_TOUCH;
        else                       act = ACT_NONE;
    end

    // Span length in byte-cycles and the saturated sum
    always_comb begin
        span    = now - last;
        incr    = 64'(span) * SCALE;
        acc_nxt = ACC_W'(sat_add(64'(acc), incr, ACC_MAX));
    end

    // Update accumulator, timestamp and armed flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            last  <= '0;
            armed <= 1'b0;
        end else if (clear) begin
            acc   <= '0;
            armed <= 1'b0;
        end else if (disarm) begin
            armed <= 1'b0;
        end else begin
            if (act == ACT_CLOSE) acc <= acc_nxt;
            if (act != ACT_NONE) begin
                last  <= now;
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/regvuln_sum.sv
// Adds all per-register accumulators into one grand total.
// Assumes TOT_W is wide enough that the sum cannot wrap.
module regvuln_sum #(
    parameter int NUM_REGS = 8,
    parameter int ACC_W    = 48,
    parameter int TOT_W    = 51
) (
    input  logic [NUM_REGS*ACC_W-1:0] acc_flat,
    output logic [TOT_W-1:0]          total
);
    // Plain linear reduction over the slots
    always_comb begin
        total = '0;
        for (int i = 0; i < NUM_REGS; i++)
            total = total + TOT_W'(acc_flat[i*ACC_W +: ACC_W]);
    end
endmodule

// File: rtl/regvuln_monitor.sv
// Register vulnerability interval monitor (top).
// It snoops two read ports and one write port of a register file and
// accumulates, per register, the byte-cycles of spans that reads close.
// Tracking runs between run_start and run_stop. Accesses in the start or
// stop cycle are ignored, and indices beyond NUM_REGS match no register.
module regvuln_monitor #(
    parameter int NUM_REGS  = 8,
    parameter int REG_BYTES = 4,
    parameter int TS_W      = 32,
    parameter int ACC_W     = 48,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TOT_W    = ACC_W + IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             run_stop,
    input  logic             rd0_vld,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic             rd1_vld,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic [ACC_W-1:0] qry_data,
    output logic [TOT_W-1:0] total
);
    logic [TS_W-1:0]           now;
    logic                      running;
    logic                      track_en;
    logic [NUM_REGS-1:0]       rd_hit;
    logic [NUM_REGS-1:0]       wr_hit;
    logic [NUM_REGS*ACC_W-1:0] acc_flat;

    regvuln_cyc #(.TS_W(TS_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    // Run window: start opens it, stop closes it
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (run_start) running <= 1'b1;
        else if (run_stop)  running <= 1'b0;
    end

    assign track_en = running && !run_start && !run_stop;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        // Decode port hits; a double read of one register is one hit
        assign rd_hit[g] = track_en &&
                           ((rd0_vld && rd0_idx == IDX_W'(g)) ||
                            (rd1_vld && rd1_idx == IDX_W'(g)));
        assign wr_hit[g] = track_en && wr_vld && wr_idx == IDX_W'(g);

        regvuln_slot #(
            .TS_W      (TS_W),
            .ACC_W     (ACC_W),
            .REG_BYTES (REG_BYTES)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (run_start),
            .disarm (run_stop),
            .rd_hit (rd_hit[g]),
            .wr_hit (wr_hit[g]),
            .now    (now),
            .acc    (acc_flat[g*ACC_W +: ACC_W])
        );
    end

    regvuln_sum #(
        .NUM_REGS (NUM_REGS),
        .ACC_W    (ACC_W),
        .TOT_W    (TOT_W)
    ) u_sum (
        .acc_flat (acc_flat),
        .total    (total)
    );

    // Registered query port: one cycle from index to data
    always_ff @(posedge clk) begin
        if (!rst_n)                           qry_data <= '0;
        else if (32'(qry_idx) < NUM_REGS)     qry_data <= acc_flat[32'(qry_idx)*ACC_W +: ACC_W];
        else                                  qry_data <= '0;
    end
endmodule

// File: rtl/regvuln_monitor_chk.sv
// Assertion checker for regvuln_monitor, attached by bind.
// It assumes qry_idx stays below NUM_REGS whenever the query is checked.
module regvuln_monitor_chk #(
    parameter int NUM_REGS = 8,
    parameter int ACC_W    = 48,
    parameter int IDX_W    = 3,
    parameter int TOT_W    = 52
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run_start,
    input logic                      rd0_vld,
    input logic                      rd1_vld,
    input logic [IDX_W-1:0]          qry_idx,
    input logic [ACC_W-1:0]          qry_data,
    input logic [TOT_W-1:0]          total,
    input logic [NUM_REGS*ACC_W-1:0] acc_flat
);
    logic             past_ok;
    logic [ACC_W-1:0] sel;

    // Marks cycles whose previous edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Slot currently addressed by the query index
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (32'(qry_idx) == i) sel = acc_flat[i*ACC_W +: ACC_W];
    end

    p_query_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> qry_data == $past(sel));

    p_total_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(run_start) |-> total >= $past(total));

    p_no_read_no_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!rd0_vld && !rd1_vld && !run_start) |-> $stable(total));

    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(run_start) |-> total == '0);
endmodule

bind regvuln_monitor regvuln_monitor_chk #(
    .NUM_REGS (NUM_REGS),
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W),
    .TOT_W    (TOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .rd0_vld   (rd0_vld),
    .rd1_vld   (rd1_vld),
    .qry_idx   (qry_idx),
    .qry_data  (qry_data),
    .total     (total),
    .acc_flat  (acc_flat)
);

// File: tb/regvuln_monitor_test.sv
module regvuln_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 8;
    localparam int BYTES = 4;
    localparam int AW    = 14;
    localparam int IW    = 3;
    localparam int TW    = AW + IW + 1;
    localparam longint AMAX = (64'd1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 0, run_stop = 0;
    logic rd0_vld = 0, rd1_vld = 0, wr_vld = 0;
    logic [IW-1:0] rd0_idx = 0, rd1_idx = 0, wr_idx = 0, qry_idx = 0;
    logic [AW-1:0] qry_data;
    logic [TW-1:0] total;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint m_acc [NREG];
    longint m_last [NREG];
    bit     m_armed [NREG];
    bit     m_run;
    longint m_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    regvuln_monitor #(.NUM_REGS(NREG), .REG_BYTES(BYTES), .TS_W(32), .ACC_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_stop(run_stop),
        .rd0_vld(rd0_vld), .rd0_idx(rd0_idx), .rd1_vld(rd1_vld), .rd1_idx(rd1_idx),
        .wr_vld(wr_vld), .wr_idx(wr_idx), .qry_idx(qry_idx),
        .qry_data(qry_data), .total(total)
    );

    function automatic longint model_sum();
        longint s = 0;
        for (int i = 0; i < NREG; i++) s += m_acc[i];
        return s;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply this cycle's inputs to the model (start beats stop)
    task automatic model_update();
        if (run_start) begin
            for (int i = 0; i < NREG; i++) begin m_acc[i] = 0; m_armed[i] = 0; end
            m_run = 1;
        end else if (run_stop) begin
            for (int i = 0; i < NREG; i++) m_armed[i] = 0;
            m_run = 0;
        end else if (m_run) begin
            for (int i = 0; i < NREG; i++) begin
                bit rd, wr;
                rd = (rd0_vld && rd0_idx == i) || (rd1_vld && rd1_idx == i);
                wr = wr_vld && wr_idx == i;
                if (rd && m_armed[i]) begin
                    m_acc[i] += (m_cyc - m_last[i]) * BYTES;
                    if (m_acc[i] > AMAX) m_acc[i] = AMAX;
                end
                if (rd || wr) begin m_last[i] = m_cyc; m_armed[i] = 1; end
            end
        end
        m_cyc++;
    endtask

    // One clock with the present inputs; outputs checked at the next falling edge
    task automatic tick(string req);
        longint exp_q;
        exp_q = m_acc[qry_idx];
        model_update();
        @(negedge clk);
        check(longint'(qry_data) == exp_q, {req, " query"}, longint'(qry_data), exp_q);
        check(longint'(total) == model_sum(), {req, " total"}, longint'(total), model_sum());
    endtask

    task automatic idle_inputs();
        run_start = 0; run_stop = 0; rd0_vld = 0; rd1_vld = 0; wr_vld = 0;
    endtask

    task automatic idle(int n, string req);
        idle_inputs();
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic do_rd(int r, string req);
        idle_inputs(); rd0_vld = 1; rd0_idx = IW'(r); tick(req); idle_inputs();
    endtask

    task automatic do_wr(int r, string req);
        idle_inputs(); wr_vld = 1; wr_idx = IW'(r); tick(req); idle_inputs();
    endtask

    task automatic pulse_start(string req);
        idle_inputs(); run_start = 1; tick(req); idle_inputs();
    endtask

    // Query register r and compare with a fixed value worked out by hand
    task automatic peek(int r, longint exp, string req);
        idle_inputs(); qry_idx = IW'(r); tick(req);
        check(longint'(qry_data) == exp, {req, " fixed"}, longint'(qry_data), exp);
    endtask

    initial begin
        #(longint'(CLK_PERIOD) * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_acc[i] = 0; m_last[i] = 0; m_armed[i] = 0; end
        m_run = 0; m_cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(qry_data == 0, "R1 query", longint'(qry_data), 0);
        check(total == 0, "R1 total", longint'(total), 0);

        // R6: before any start, accesses are ignored
        do_wr(2, "R6");
        do_rd(2, "R6");
        check(total == 0, "R6 pre-start", longint'(total), 0);

        pulse_start("R6");
        // R5: first access after start adds nothing
        do_rd(1, "R5");
        check(total == 0, "R5 first read", longint'(total), 0);

        // R2: write then read six edges later -> 6*4
        do_wr(2, "R2");
        idle(5, "R2");
        do_rd(2, "R2");
        peek(2, 24, "R2");
        // R3: read after read, three edges later -> +12
        idle(1, "R3");
        do_rd(2, "R3");
        peek(2, 36, "R3");

        // R4: write-closed span adds nothing
        do_wr(3, "R4");
        idle(3, "R4");
        do_wr(3, "R4");
        peek(3, 0, "R4");

        // R7: read and write of one register in one cycle; read goes first
        do_wr(2, "R7");
        idle(1, "R7");
        idle_inputs(); rd0_vld = 1; rd0_idx = 2; wr_vld = 1; wr_idx = 2; tick("R7");
        idle(2, "R7");
        do_rd(2, "R7");
        peek(2, 56, "R7");

        // R8: both ports read one register -> counted once
        do_wr(4, "R8");
        idle_inputs(); rd0_vld = 1; rd0_idx = 4; rd1_vld = 1; rd1_idx = 4; tick("R8");
        peek(4, 4, "R8");

        // R6: after stop, reads are ignored; start clears totals
        idle_inputs(); run_stop = 1; tick("R6");
        do_rd(4, "R6");
        peek(4, 4, "R6");
        pulse_start("R6");
        check(total == 0, "R6 cleared", longint'(total), 0);
        do_rd(4, "R5");
        peek(4, 0, "R5");

        // R9: a long span saturates and stays saturated
        do_wr(5, "R9");
        idle(4100, "R9");
        do_rd(5, "R9");
        peek(5, AMAX, "R9");
        do_rd(5, "R9");
        peek(5, AMAX, "R9");

        // R10 with R2/R3: random traffic, model checks every cycle
        begin
            int unsigned seed_v;
            seed_v = $urandom(32'h5eed_1234);
            for (int n = 0; n < 3000; n++) begin
                idle_inputs();
                if (n % 400 == 0) run_start = 1;
                else if ($urandom_range(0, 299) == 0) run_stop = 1;
                rd0_vld = ($urandom_range(0, 3) == 0);
                rd0_idx = IW'($urandom_range(0, NREG - 1));
                rd1_vld = ($urandom_range(0, 4) == 0);
                rd1_idx = IW'($urandom_range(0, NREG - 1));
                wr_vld  = ($urandom_range(0, 3) == 0);
                wr_idx  = IW'($urandom_range(0, NREG - 1));
                qry_idx = IW'($urandom_range(0, NREG - 1));
                tick("R10");
            end
        end
        idle(2, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule